// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a serial-bus target that gives a host controller read and write access to a small bank of 8-bit configuration registers. It receives SCL and SDA already synchronized to the local clock and oversampled. It finds START, repeated START and STOP conditions. It compares the first byte of every frame with a fixed 7-bit device address, and it pulls SDA low through an open-drain output enable whenever it acknowledges a byte or sends a zero bit.

In a write frame the byte after the address sets an internal register pointer. Each later byte goes to the register the pointer selects, and the pointer then steps by one. A read frame sends register contents MSB first, again stepping the pointer after every byte. A read that opens with a plain START always begins at register 0x00. A read keeps the preset pointer only when it follows a pointer write through a repeated START in the same frame. Registers 0x00 to 0x12 exist. The rest of the 8-bit space is reserved: writes there are acknowledged and dropped, reads give zero, and the top address 0xFF returns a fixed revision byte. Each register has its own write strobe, and the whole bank is visible in parallel on an output bus.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The device answers to 7-bit address 1001101. The R/W flag is bit 0 of the first byte after a START, so 0x9A selects a write and 0x9B a read. The device acknowledges by holding SDA low for the whole ninth SCL clock of the byte.
- R2: In a write frame, the byte after the address loads the pointer and is acknowledged. Every later byte is acknowledged and stored in the register at the pointer. The store raises exactly the one strobe bit whose index equals the pointer, and no register changes without a strobe.
- R3: The pointer steps by one after every data byte, whether written or read, and wraps from 0xFF to 0x00.
- R4: A read address that follows a plain START, with no pointer byte since that START, sets the pointer to 0x00. This includes any read frame that comes after a STOP.
- R5: After a pointer byte, a repeated START with a read address starts reading at the register that pointer byte selected.
- R6: Read data leaves MSB first, and SDA changes only while SCL is low. A master acknowledge (SDA low on the ninth clock) fetches the next byte. A master not-acknowledge makes the device release SDA and stay off the bus until the next START.
- R7: Writes to pointers 0x13 to 0xFF are acknowledged, change no register and raise no strobe.
- R8: Reads from pointers 0x13 to 0xFE return 0x00. A read from 0xFF returns the revision byte (default 0x42).
- R9: An address byte whose upper seven bits differ from 1001101 gets no acknowledge. All later bytes are then ignored and not acknowledged until the next START.
- R10: A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP. A STOP inside the same SCL high phase as the START before it is ignored.
- R11: A STOP at any bit position ends the frame and releases SDA. A partly received byte is discarded.
- R12: After reset all registers read 0x00, SDA is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; the bus lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired bus level) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| wr_stb_o | output | NREG | One-cycle write strobe, one bit per register |
| wr_data_o | output | 8 | Byte that goes with the active strobe |
| regs_o | output | NREG*8 | Register contents, register k in bits 8k+7..8k |

## Verification
Two detector functions can act in the same SCL high phase: the START recognizer and the STOP recognizer. The bench provokes this by lowering and then raising SDA while SCL stays high. It then expects the device to treat the following byte as an address and acknowledge it, because the STOP must have been masked. A second collision is a STOP that lands mid-byte just after a pointer byte. A cycle-by-cycle model of the register image and of the SDA enable, compared on every clock, shows that no register changed and that SDA was released.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK0,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } ctl_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/cfgi2c_busmon.sv
module cfgi2c_busmon
  import cfgi2c_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;
  logic hold_q, hold_d;
  logic stop_raw;

  // edge and condition decode
  always_comb begin
    ev_o.scl_rise = scl_i & ~scl_q;
    ev_o.scl_fall = ~scl_i & scl_q;
    ev_o.start    = scl_i & scl_q & sda_q & ~sda_i;
    stop_raw      = scl_i & scl_q & ~sda_q & sda_i;
    // a STOP is masked while still in the SCL high phase of a START
    ev_o.stop     = stop_raw & ~hold_q;
    hold_d        = hold_q;
    if (ev_o.start) begin
      hold_d = 1'b1;
    end else if (ev_o.scl_fall) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/cfgi2c_ctrl.sv
module cfgi2c_ctrl
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o,
  output logic              idle_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  ctl_state_e        state_q, state_d;
  byte_kind_e        kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              ptr_set_q, ptr_set_d;
  logic              go_tx_q, go_tx_d;
  logic              seen9_q, seen9_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;
  logic              wen_q, wen_d;
  logic [BYTE_W-1:0] waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {sr_q[BYTE_W-2:0], sda_i};

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    cnt_d     = cnt_q;
    sr_d      = sr_q;
    ptr_d     = ptr_q;
    ptr_set_d = ptr_set_q;
    go_tx_d   = go_tx_q;
    seen9_d   = seen9_q;
    mack_d    = mack_q;
    oe_d      = oe_q;
    wen_d     = 1'b0;
    waddr_d   = waddr_q;
    wdata_d   = wdata_q;
    if (ev_i.start) begin
      state_d = ST_RX;
      kind_d  = BK_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (ev_i.stop) begin
      state_d   = ST_IDLE;
      oe_d      = 1'b0;
      ptr_set_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_RX: begin
          if (ev_i.scl_rise) begin
            sr_d  = byte_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RX_ACK0;
              seen9_d = 1'b0;
              unique case (kind_q)
                BK_ADDR: begin
                  if (byte_in[BYTE_W-1:1] == DEV_ADDR) begin
                    go_tx_d = byte_in[0];
                    kind_d  = BK_PTR;
                    if (byte_in[0]) begin
                      if (!ptr_set_q) ptr_d = '0;
                      ptr_set_d = 1'b0;
                    end
                  end else begin
                    state_d = ST_IDLE;
                  end
                end
                BK_PTR: begin
                  ptr_d     = byte_in;
                  ptr_set_d = 1'b1;
                  kind_d    = BK_DATA;
                end
                default: begin
                  wen_d   = 1'b1;
                  waddr_d = ptr_q;
                  wdata_d = byte_in;
                  ptr_d   = ptr_q + 1'b1;
                end
              endcase
            end
          end
        end
        ST_RX_ACK0: begin
          if (ev_i.scl_fall) begin
            oe_d    = 1'b1;
            state_d = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (ev_i.scl_rise) seen9_d = 1'b1;
          if (ev_i.scl_fall && seen9_q) begin
            cnt_d = '0;
            if (go_tx_q) begin
              sr_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev_i.scl_rise) cnt_d = cnt_q + 1'b1;
          if (ev_i.scl_fall) begin
            if (cnt_q == ALL_BITS) begin
              oe_d    = 1'b0;
              seen9_d = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              sr_d = {sr_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sr_q[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (ev_i.scl_rise) begin
            seen9_d = 1'b1;
            mack_d  = ~sda_i;
          end
          if (ev_i.scl_fall && seen9_q) begin
            cnt_d = '0;
            if (mack_q) begin
              sr_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= BK_ADDR;
      cnt_q     <= '0;
      sr_q      <= '0;
      ptr_q     <= '0;
      ptr_set_q <= 1'b0;
      go_tx_q   <= 1'b0;
      seen9_q   <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      wen_q     <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      cnt_q     <= cnt_d;
      sr_q      <= sr_d;
      ptr_q     <= ptr_d;
      ptr_set_q <= ptr_set_d;
      go_tx_q   <= go_tx_d;
      seen9_q   <= seen9_d;
      mack_q    <= mack_d;
      oe_q      <= oe_d;
      wen_q     <= wen_d;
      waddr_q   <= waddr_d;
      wdata_q   <= wdata_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wen_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
  assign sda_oe_o  = oe_q;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
  import cfgi2c_pkg::*;
#(
  parameter int          NREG   = 19,
  parameter logic [7:0]  REV_ID = 8'h42
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [BYTE_W-1:0]      wr_addr_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  input  logic [BYTE_W-1:0]      rd_addr_i,
  output logic [BYTE_W-1:0]      rd_data_o,
  output logic [NREG-1:0]        wr_stb_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  localparam logic [BYTE_W-1:0] REV_ADDR = '1;

  logic [BYTE_W-1:0] bank_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // decode: reserved pointers match no slot and raise no strobe
    assign wr_stb_o[g] = wr_en_i && (wr_addr_i == BYTE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (wr_stb_o[g]) begin
        bank_q[g] <= wr_data_i;
      end
    end

    assign regs_o[g*BYTE_W +: BYTE_W] = bank_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr_i == BYTE_W'(i)) rd_data_o = bank_q[i];
    end
    if (rd_addr_i == REV_ADDR) rd_data_o = REV_ID;
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfgi2c_pkg::*;
#(
  parameter int         NREG     = 19,
  parameter logic [6:0] DEV_ADDR = 7'h4D,
  parameter logic [7:0] REV_ID   = 8'h42
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NREG-1:0]        wr_stb_o,
  output logic [BYTE_W-1:0]      wr_data_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  logic              rst_meta, rst_int_n;
  bus_ev_t           bus_ev;
  logic              start_det, stop_det, ctrl_idle;
  logic [BYTE_W-1:0] ptr, rd_data, wr_addr;
  logic              wr_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  cfgi2c_busmon u_busmon (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (bus_ev)
  );

  assign start_det = bus_ev.start;
  assign stop_det  = bus_ev.stop;

  cfgi2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ev_i      (bus_ev),
    .sda_i     (sda_i),
    .rd_data_i (rd_data),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data_o),
    .sda_oe_o  (sda_oe_o),
    .idle_o    (ctrl_idle)
  );

  cfgi2c_regbank #(.NREG(NREG), .REV_ID(REV_ID)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data_o),
    .rd_addr_i (ptr),
    .rd_data_o (rd_data),
    .wr_stb_o  (wr_stb_o),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NREG = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG-1:0]   wr_stb,
  input logic [NREG*8-1:0] regs,
  input logic              start_det,
  input logic              stop_det,
  input logic              ctrl_idle
);
  // R6: the data enable only moves while SCL is low (release is always allowed)
  a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_i || !sda_oe));

  // R2: at most one register strobe at a time
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  // R2: a register image change always follows a strobe
  a_r2_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(|wr_stb));

  // R10: a START frees the data line
  a_r10_start_frees: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R11: a STOP frees the data line
  a_r11_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R9: an idle controller never drives the bus
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle |-> !sda_oe);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe_o),
  .wr_stb    (wr_stb_o),
  .regs      (regs_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .ctrl_idle (ctrl_idle)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;
  localparam int         NREG   = 19;
  localparam logic [7:0] REV    = 8'h42;
  localparam int         H      = 8;
  localparam int         SETTLE = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              scl_m, sda_m;
  logic              sda_oe;
  logic [NREG-1:0]   wr_stb;
  logic [7:0]        wr_data;
  logic [NREG*8-1:0] regs;
  wire               sda_bus = sda_m & ~sda_oe;

  cfg_i2c_slave #(.NREG(NREG), .DEV_ADDR(7'h4D), .REV_ID(REV)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .wr_stb_o (wr_stb),
    .wr_data_o(wr_data),
    .regs_o   (regs)
  );

  int    cyc = 0, last_touch = 0, n_cmp = 0, n_bad = 0, stb_total = 0;
  bit    live = 0, done = 0;
  string cur_req = "R12";
  logic [7:0] m_regs [NREG];
  int    m_ptr = 0;
  bit    m_ptr_set = 0;
  logic  exp_oe = 1'b0;
  int    stb_cnt [NREG];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input int p);
    if (p < NREG) return m_regs[p];
    if (p == 255) return REV;
    return 8'h00;
  endfunction

  task automatic model_wr(input logic [7:0] b);
    if (m_ptr < NREG) m_regs[m_ptr] = b;
    m_ptr = (m_ptr + 1) & 255;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (live) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_stb[i]) begin
          stb_cnt[i]++;
          stb_total++;
        end
      end
    end
  end

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (live && !done && (cyc - last_touch >= SETTLE)) begin
      check(sda_oe === exp_oe, cur_req, "sda_oe", 32'(sda_oe), 32'(exp_oe));
      for (int i = 0; i < NREG; i++) begin
        if (regs[i*8 +: 8] !== m_regs[i])
          check(1'b0, cur_req, $sformatf("reg %0d", i), 32'(regs[i*8 +: 8]), 32'(m_regs[i]));
      end
      n_cmp++;
    end
  end

  task automatic mark();
    last_touch = cyc;
  endtask

  task automatic wait_h();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b0; mark(); wait_h();
    scl_m = 1'b0; mark(); wait_h();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; mark(); wait_h();
    scl_m = 1'b1; mark(); wait_h();
    sda_m = 1'b0; mark(); wait_h();
    scl_m = 1'b0; mark(); wait_h();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; mark(); wait_h();
    scl_m = 1'b1; mark(); wait_h();
    sda_m = 1'b1; exp_oe = 1'b0; m_ptr_set = 0; mark(); wait_h();
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit exp_ack, input bit is_data,
                         input bit to_read, input string req);
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; mark(); wait_h();
      scl_m = 1'b1; mark();
      if (i == 0 && is_data && exp_ack) model_wr(b);
      wait_h();
      scl_m = 1'b0;
      if (i == 0) begin
        exp_oe = exp_ack;
        sda_m  = 1'b1;
      end
      mark();
    end
    wait_h();
    scl_m = 1'b1; mark(); wait_h();
    check(sda_bus === ~exp_ack, req, "ack level", 32'(sda_bus), 32'(~exp_ack));
    scl_m = 1'b0;
    exp_oe = (to_read && exp_ack) ? ~model_rd(m_ptr)[7] : 1'b0;
    mark(); wait_h();
  endtask

  task automatic addr_read(input string req);
    if (!m_ptr_set) m_ptr = 0;
    m_ptr_set = 0;
    tx_byte(8'h9B, 1'b1, 1'b0, 1'b1, req);
  endtask

  task automatic set_ptr(input logic [7:0] p, input string req);
    m_ptr = p;
    m_ptr_set = 1;
    tx_byte(p, 1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic rx_byte(input bit mack, input string req);
    logic [7:0] cur, got;
    cur_req = req;
    cur = model_rd(m_ptr);
    m_ptr = (m_ptr + 1) & 255;
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_h();
      scl_m = 1'b1; mark(); wait_h();
      got[i] = sda_bus;
      scl_m = 1'b0;
      exp_oe = (i > 0) ? ~cur[i-1] : 1'b0;
      mark();
    end
    sda_m = mack ? 1'b0 : 1'b1; mark(); wait_h();
    scl_m = 1'b1; mark(); wait_h();
    scl_m = 1'b0;
    exp_oe = mack ? ~model_rd(m_ptr)[7] : 1'b0;
    sda_m = 1'b1; mark(); wait_h();
    check(got === cur, req, "read byte", 32'(got), 32'(cur));
    if (!mack) check(sda_oe === 1'b0, "R6", "released after NACK", 32'(sda_oe), 0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      m_regs[i] = 8'h00;
      stb_cnt[i] = 0;
    end
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    // R12 reset state
    check(regs === '0, "R12", "regs after reset", 32'(regs[31:0]), 0);
    check(sda_oe === 1'b0, "R12", "sda_oe after reset", 32'(sda_oe), 0);
    check(wr_stb === '0, "R12", "strobes after reset", 32'(wr_stb), 0);
    live = 1;
    mark();

    // R1 R2 R3: write three bytes from pointer 0x03
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R1");
    set_ptr(8'h03, "R2");
    tx_byte(8'hA5, 1'b1, 1'b1, 1'b0, "R2");
    tx_byte(8'h3C, 1'b1, 1'b1, 1'b0, "R3");
    tx_byte(8'h0F, 1'b1, 1'b1, 1'b0, "R3");
    bus_stop();
    check(regs[3*8 +: 8] === 8'hA5, "R2", "reg3", 32'(regs[3*8 +: 8]), 32'hA5);
    check(regs[5*8 +: 8] === 8'h0F, "R3", "reg5 autoinc", 32'(regs[5*8 +: 8]), 32'h0F);
    check(stb_cnt[4] == 1, "R2", "strobe count reg4", 32'(stb_cnt[4]), 1);

    // R5: pointer write then repeated START read
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R5");
    set_ptr(8'h04, "R5");
    bus_rstart();
    addr_read("R5");
    rx_byte(1'b1, "R5");
    rx_byte(1'b1, "R3");
    rx_byte(1'b0, "R6");
    bus_stop();

    // R4: plain START read begins at 0x00 despite an earlier pointer write
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R4");
    set_ptr(8'h00, "R4");
    tx_byte(8'h5A, 1'b1, 1'b1, 1'b0, "R4");
    bus_stop();
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R4");
    set_ptr(8'h02, "R4");
    bus_stop();
    bus_start();
    addr_read("R4");
    rx_byte(1'b1, "R4");
    rx_byte(1'b0, "R4");
    bus_stop();

    // R7 R8: write across the end of the bank, read a reserved slot
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R7");
    set_ptr(8'h11, "R7");
    tx_byte(8'h11, 1'b1, 1'b1, 1'b0, "R7");
    tx_byte(8'h22, 1'b1, 1'b1, 1'b0, "R7");
    tx_byte(8'h33, 1'b1, 1'b1, 1'b0, "R7");
    bus_rstart();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R8");
    set_ptr(8'h12, "R8");
    bus_rstart();
    addr_read("R8");
    rx_byte(1'b1, "R8");
    rx_byte(1'b0, "R8");
    bus_stop();
    check(regs[18*8 +: 8] === 8'h22, "R7", "reg 0x12", 32'(regs[18*8 +: 8]), 32'h22);

    // R8 R3: revision byte and pointer wrap in both directions
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R8");
    set_ptr(8'hFF, "R8");
    bus_rstart();
    addr_read("R8");
    rx_byte(1'b1, "R8");
    rx_byte(1'b0, "R3");
    bus_stop();
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R3");
    set_ptr(8'hFF, "R3");
    tx_byte(8'h77, 1'b1, 1'b1, 1'b0, "R7");
    tx_byte(8'h99, 1'b1, 1'b1, 1'b0, "R3");
    bus_stop();
    check(regs[7:0] === 8'h99, "R3", "reg0 after wrap", 32'(regs[7:0]), 32'h99);

    // R9: foreign address, ignored bytes, then a repeated START recovers
    bus_start();
    tx_byte(8'h90, 1'b0, 1'b0, 1'b0, "R9");
    tx_byte(8'h07, 1'b0, 1'b0, 1'b0, "R9");
    tx_byte(8'hEE, 1'b0, 1'b0, 1'b0, "R9");
    bus_rstart();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R9");
    set_ptr(8'h07, "R9");
    tx_byte(8'h44, 1'b1, 1'b1, 1'b0, "R9");
    bus_stop();
    check(regs[7*8 +: 8] === 8'h44, "R9", "reg7", 32'(regs[7*8 +: 8]), 32'h44);

    // R10: STOP inside the START high phase is ignored
    cur_req = "R10";
    sda_m = 1'b0; mark(); wait_h();
    sda_m = 1'b1; mark(); wait_h();
    scl_m = 1'b0; mark(); wait_h();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R10");
    set_ptr(8'h08, "R10");
    tx_byte(8'h81, 1'b1, 1'b1, 1'b0, "R10");
    bus_stop();
    check(regs[8*8 +: 8] === 8'h81, "R10", "reg8", 32'(regs[8*8 +: 8]), 32'h81);

    // R11: STOP after three bits of a data byte
    bus_start();
    tx_byte(8'h9A, 1'b1, 1'b0, 1'b0, "R11");
    set_ptr(8'h09, "R11");
    cur_req = "R11";
    for (int i = 0; i < 3; i++) begin
      sda_m = (i < 2); mark(); wait_h();
      scl_m = 1'b1; mark(); wait_h();
      scl_m = 1'b0; mark();
    end
    wait_h();
    bus_stop();
    check(regs[9*8 +: 8] === 8'h00, "R11", "reg9 after abort", 32'(regs[9*8 +: 8]), 0);
    check(stb_cnt[9] == 0, "R11", "reg9 strobes", 32'(stb_cnt[9]), 0);
    check(sda_oe === 1'b0, "R11", "sda released", 32'(sda_oe), 0);
    bus_start();
    addr_read("R11");
    rx_byte(1'b0, "R11");
    bus_stop();

    // R7: reserved writes raised no strobe (3+1+2+1+1+1 in-range stores)
    check(stb_total == 9, "R7", "total strobes", 32'(stb_total), 9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog %s: actual hung expected finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule